// File: doc/BRIEF.md
# Asynchronous Two-Master Bus Arbiter

This block lets two Wishbone masters share one group of slave devices. Each master sees the shared group as a single extra slave placed in its own termination chain. The shared slaves see the block as one master. Only the handshake lines pass through the block: cycle, strobe, write enable, acknowledge, retry and error. Address, data and byte-select buses are switched by an external multiplexer, which the block steers through one select output.

The block has no clock. Ownership of the shared bus is held in a level-sensitive latch. Every path from a master's request to the shared bus, and from a slave's termination back to the owning master, is combinational. Zero-wait-state transfers therefore pass through without adding a cycle. A master keeps ownership for as long as its cycle line stays high, so block transfers and read-modify-write sequences are never split between the two masters.

A master that is refused ownership sees only its own chain inputs on its termination outputs. It keeps waiting until the owner lowers its cycle line.

Top module: `arb2_bus_share`

## Requirements
- R1: While `rst` is high, neither master owns the shared bus. `s_cyc`, `s_stb`, `s_we` and `sel_b` are all 0, whatever the master inputs are.
- R2: When no master owns the bus and exactly one master raises its cycle line, that master owns the bus at once. `s_cyc` and `s_we` then follow that master's cycle and write-enable lines.
- R3: When both cycle lines are high and no master owns the bus, master A receives ownership. This covers a simultaneous request and the moment reset is released.
- R4: While the owner's cycle line is high, ownership does not change, whatever the other master does.
- R5: When the owner lowers its cycle line while the other master's cycle line is high, ownership passes to the waiting master with no gap.
- R6: `s_stb` and `s_we` are driven only from the owner's strobe and write-enable lines. The non-owner's strobe and write-enable have no effect. With no owner, both outputs are 0.
- R7: Each termination output (acknowledge, retry, error) of the owning master is the OR of its chain input and the matching shared-slave termination. The non-owner gets its chain input only.
- R8: A master's chain inputs reach its termination outputs in every state, including during reset.
- R9: `sel_b` is 1 exactly when master B owns the bus, and 0 otherwise (A owns, or no owner). The external multiplexer takes master A's buses when `sel_b` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Active-high reset; clears ownership |
| a_cyc | input | 1 | Master A cycle (block frame) |
| a_stb | input | 1 | Master A strobe for this target |
| a_we | input | 1 | Master A write enable |
| a_ack_in | input | 1 | Master A acknowledge chain input |
| a_rty_in | input | 1 | Master A retry chain input |
| a_err_in | input | 1 | Master A error chain input |
| a_ack | output | 1 | Master A merged acknowledge |
| a_rty | output | 1 | Master A merged retry |
| a_err | output | 1 | Master A merged error |
| b_cyc | input | 1 | Master B cycle (block frame) |
| b_stb | input | 1 | Master B strobe for this target |
| b_we | input | 1 | Master B write enable |
| b_ack_in | input | 1 | Master B acknowledge chain input |
| b_rty_in | input | 1 | Master B retry chain input |
| b_err_in | input | 1 | Master B error chain input |
| b_ack | output | 1 | Master B merged acknowledge |
| b_rty | output | 1 | Master B merged retry |
| b_err | output | 1 | Master B merged error |
| s_cyc | output | 1 | Shared-bus cycle |
| s_stb | output | 1 | Shared-bus strobe |
| s_we | output | 1 | Shared-bus write enable |
| s_ack | input | 1 | Shared-slave acknowledge |
| s_rty | input | 1 | Shared-slave retry |
| s_err | input | 1 | Shared-slave error |
| sel_b | output | 1 | Multiplexer select: 1 picks master B's buses |

## Verification
A wrong ownership state shows up at the ports with no delay. If the latch holds the wrong owner, `sel_b` takes the wrong value and `s_we` follows the wrong master. A slave termination then reaches the master that did not issue the access. If ownership moves while the owner's cycle line is high, `sel_b` changes in the middle of a block. So every ownership sequence is checked at once, by looking at `sel_b`, `s_cyc` and `s_we` after each change of the cycle lines. The routing of strobe, write enable and the terminations is swept over every input combination, for each owner and for the reset state.

// File: rtl/arb2_bus_share.sv
module arb2_bus_share (
  input  logic rst,
  input  logic a_cyc,
  input  logic a_stb,
  input  logic a_we,
  input  logic a_ack_in,
  input  logic a_rty_in,
  input  logic a_err_in,
  output logic a_ack,
  output logic a_rty,
  output logic a_err,
  input  logic b_cyc,
  input  logic b_stb,
  input  logic b_we,
  input  logic b_ack_in,
  input  logic b_rty_in,
  input  logic b_err_in,
  output logic b_ack,
  output logic b_rty,
  output logic b_err,
  output logic s_cyc,
  output logic s_stb,
  output logic s_we,
  input  logic s_ack,
  input  logic s_rty,
  input  logic s_err,
  output logic sel_b
);

  logic own_a, own_b, free;

  // ownership may move only when the current owner has dropped its cycle
  assign free = ~(own_a & a_cyc) & ~(own_b & b_cyc);

  always_latch begin
    if (rst) begin
      own_a <= 1'b0;
      own_b <= 1'b0;
    end else if (free) begin
      own_a <= a_cyc;
      own_b <= b_cyc & ~a_cyc;
    end
  end

  assign s_cyc = (own_a & a_cyc) | (own_b & b_cyc);
  assign s_stb = (own_a & a_stb) | (own_b & b_stb);
  assign s_we  = (own_a & a_we)  | (own_b & b_we);
  assign sel_b = own_b;

  assign a_ack = a_ack_in | (own_a & s_ack);
  assign a_rty = a_rty_in | (own_a & s_rty);
  assign a_err = a_err_in | (own_a & s_err);
  assign b_ack = b_ack_in | (own_b & s_ack);
  assign b_rty = b_rty_in | (own_b & s_rty);
  assign b_err = b_err_in | (own_b & s_err);

endmodule

// File: rtl/arb2_bus_share_chk.sv
module arb2_bus_share_chk (
  input logic rst,
  input logic a_cyc,
  input logic b_cyc,
  input logic s_cyc,
  input logic s_stb,
  input logic s_we,
  input logic sel_b,
  input logic a_ack,
  input logic a_ack_in,
  input logic b_ack,
  input logic b_ack_in,
  input logic s_ack
);

  always_comb begin
    if (rst) begin
      a_r1_reset_quiet: assert (!s_cyc && !s_stb && !s_we && !sel_b);
    end
    if (!rst) begin
      a_r2_cyc_has_source: assert (!s_cyc || a_cyc || b_cyc);
    end
    a_r7_a_term_source: assert (!a_ack || a_ack_in || s_ack);
    a_r7_b_term_source: assert (!b_ack || b_ack_in || s_ack);
    a_r7_single_target: assert (!((a_ack && !a_ack_in) && (b_ack && !b_ack_in)));
  end

  // B may only take over after A has dropped its cycle line
  always @(posedge sel_b) begin
    a_r4_a_not_preempted: assert (!a_cyc);
  end

  // B may only lose ownership after its own cycle ends, or by reset
  always @(negedge sel_b) begin
    if (!rst) begin
      a_r4_b_keeps_grant: assert (!b_cyc);
    end
  end

endmodule

bind arb2_bus_share arb2_bus_share_chk u_chk (
  .rst(rst), .a_cyc(a_cyc), .b_cyc(b_cyc), .s_cyc(s_cyc), .s_stb(s_stb),
  .s_we(s_we), .sel_b(sel_b), .a_ack(a_ack), .a_ack_in(a_ack_in),
  .b_ack(b_ack), .b_ack_in(b_ack_in), .s_ack(s_ack)
);

// File: tb/arb2_bus_share_tb_top.sv
`timescale 1ns/1ps
module arb2_bus_share_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  logic a_cyc, a_stb, a_we, a_ack_in, a_rty_in, a_err_in, a_ack, a_rty, a_err;
  logic b_cyc, b_stb, b_we, b_ack_in, b_rty_in, b_err_in, b_ack, b_rty, b_err;
  logic s_cyc, s_stb, s_we, s_ack, s_rty, s_err, sel_b;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  arb2_bus_share dut_i (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // owner: 0 none, 1 A, 2 B
  task automatic sweep(input int owner, input bit in_reset);
    for (int v = 0; v < 16384; v++) begin
      logic [13:0] b;
      logic e_stb, e_we, e_cyc, oa, ob;
      b = v[13:0];
      a_stb = b[0]; a_we = b[1]; b_stb = b[2]; b_we = b[3];
      if (owner == 1) begin a_cyc = 1'b1; b_cyc = b[4]; end
      else if (owner == 2) begin b_cyc = 1'b1; a_cyc = b[4]; end
      else if (in_reset) begin a_cyc = b[4]; b_cyc = b[1]; end
      else begin a_cyc = 1'b0; b_cyc = 1'b0; end
      {a_ack_in, a_rty_in, a_err_in} = b[7:5];
      {b_ack_in, b_rty_in, b_err_in} = b[10:8];
      {s_ack, s_rty, s_err} = b[13:11];
      #1;
      oa = (owner == 1); ob = (owner == 2);
      e_cyc = (oa & a_cyc) | (ob & b_cyc);
      e_stb = oa ? a_stb : (ob ? b_stb : 1'b0);
      e_we  = oa ? a_we  : (ob ? b_we  : 1'b0);
      if (owner == 0) chk("R1 shared outputs idle", {5'd0, s_cyc, s_stb, s_we}, 8'd0);
      chk("R6 strobe/we routing", {6'd0, s_stb, s_we}, {6'd0, e_stb, e_we});
      chk("R4 cycle held by owner", {7'd0, s_cyc}, {7'd0, e_cyc});
      chk("R9 mux select", {7'd0, sel_b}, {7'd0, ob});
      chk("R7 R8 A terminations", {5'd0, a_ack, a_rty, a_err},
          {5'd0, b[7:5] | (oa ? b[13:11] : 3'b000)});
      chk("R7 R8 B terminations", {5'd0, b_ack, b_rty, b_err},
          {5'd0, b[10:8] | (ob ? b[13:11] : 3'b000)});
    end
  endtask

  task automatic idle_inputs();
    {a_cyc, a_stb, a_we, a_ack_in, a_rty_in, a_err_in} = '0;
    {b_cyc, b_stb, b_we, b_ack_in, b_rty_in, b_err_in} = '0;
    {s_ack, s_rty, s_err} = '0;
  endtask

  task automatic step(input logic ac, input logic bc);
    @(negedge clk);
    a_cyc = ac; b_cyc = bc;
    #2;
  endtask

  initial begin
    rst = 1'b1;
    idle_inputs();
    a_cyc = 1'b1; b_cyc = 1'b1; a_we = 1'b1; b_we = 1'b1;
    #2;
    chk("R1 reset state", {5'd0, s_cyc, s_we, sel_b}, 8'd0);
    sweep(0, 1'b1);
    idle_inputs();
    @(negedge clk); rst = 1'b0; #2;
    sweep(0, 1'b0);

    a_we = 1'b1; b_we = 1'b0;
    step(1, 0);
    chk("R2 A alone granted", {5'd0, s_cyc, s_we, sel_b}, 8'b110);
    step(0, 0);
    chk("R2 release to idle", {6'd0, s_cyc, sel_b}, 8'd0);
    a_we = 1'b0; b_we = 1'b1;
    step(0, 1);
    chk("R2 B alone granted", {5'd0, s_cyc, s_we, sel_b}, 8'b111);
    step(0, 0);
    a_we = 1'b1; b_we = 1'b0;
    step(1, 1);
    chk("R3 simultaneous goes to A", {5'd0, s_cyc, s_we, sel_b}, 8'b110);
    @(negedge clk); b_stb = 1'b1; b_we = 1'b1; #2;
    chk("R4 A kept while B waits", {5'd0, s_cyc, s_we, sel_b}, 8'b110);
    step(0, 1);
    chk("R5 handover to B", {5'd0, s_cyc, s_we, sel_b}, 8'b111);
    step(1, 1);
    chk("R4 B kept while A waits", {6'd0, s_cyc, sel_b}, 8'b11);
    b_we = 1'b0;
    step(1, 0);
    chk("R5 handover to A", {5'd0, s_cyc, s_we, sel_b}, 8'b110);
    @(negedge clk); rst = 1'b1; #2;
    chk("R1 reset drops grant", {6'd0, s_cyc, sel_b}, 8'd0);
    b_cyc = 1'b1;
    @(negedge clk); rst = 1'b0; #2;
    chk("R3 reset release goes to A", {6'd0, s_cyc, sel_b}, 8'b10);

    step(1, 0);
    sweep(1, 1'b0);
    a_cyc = 1'b1; b_cyc = 1'b0;
    step(0, 0);
    step(0, 1);
    sweep(2, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<=150000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end
endmodule